// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a memory-mapped down-counter that gives a processor core a periodic tick. Software programs a reload value and turns the timer on through a control register. The counter then steps down once per counting tick. Each time it passes from one to zero it latches a sticky flag and, if enabled, sends a single-cycle pending request to the interrupt controller. On the tick after that it starts again from the reload value.

Counting ticks come from one of two sources. One is every cycle of the processor clock. The other is each rising edge of an external reference input, which the block synchronises and turns into a one-cycle enable. The register port is a plain single-cycle interface. Writes take effect at the clock edge. Read data is combinational from the address, and any side effect of a read is applied at the edge that ends the read cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset the control and reload registers read zero, the current-value register reads zero, the timer is stopped and `tick_irq` is low.
- R2: The control register sits at offset 0x10. Bit 0 is enable, bit 1 is interrupt enable, bit 2 selects the processor clock (1) or the reference input (0), and bit 16 is the sticky count flag. A write changes only bits 2:0, and every other bit reads zero except the flag.
- R3: A read of the control register returns the flag as it stood and then clears it, unless a new zero crossing happens at that same edge.
- R4: The reload register sits at offset 0x14 and keeps only bits 23:0. Bits 31:24 read zero.
- R5: A write of any data to the current-value register (offset 0x18) loads the counter from the reload register and clears the count flag.
- R6: When the counter steps from 1 to 0, the flag is set. If interrupt enable is set, `tick_irq` is high for exactly the one cycle after that edge. If interrupt enable is clear, `tick_irq` stays low.
- R7: A write that turns enable from 0 to 1 loads the counter from the reload register. From then on, zero crossings repeat every reload+1 counting ticks.
- R8: The current-value register reads zero whenever enable is clear.
- R9: The calibration register (offset 0x1C) reads the constant `CALIB_VAL`, and writes to it have no effect.
- R10: With bit 2 clear, each rising edge of `ref_clk_in` yields exactly one counting tick. The counter holds while that input is still.
- R11: A reload value of zero holds the counter at zero. No further flag or interrupt events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ref_clk_in | input | 1 | Asynchronous external reference clock |
| tick_irq | output | 1 | One-cycle pending request to the interrupt controller |

## Verification
A corrupted counter shows up as a zero-crossing interval that is not reload+1. The bench measures that interval to the exact cycle from the `tick_irq` pulses, so the error appears within one period. A read of the current value straight after a reload or an enable must return the reload value, and one cycle later one less. An off-by-one in loading or stepping is therefore visible within two cycles. A stuck or wrongly cleared flag appears on the next control-register read, and a missed synchronised reference edge stretches the measured period by a whole reference cycle.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          CNT_W     = 24,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CALIB_VAL = 32'h4000_0064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ref_clk_in,
  output logic              tick_irq
);
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFF_RLD   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFF_CUR   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFF_CALIB = ADDR_W'('h1C);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

  logic             en_q, ie_q, src_q, flag_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [2:0]       ref_sync;

  wire wr_ctrl  = bus_wr & (bus_addr == OFF_CTRL);
  wire wr_rld   = bus_wr & (bus_addr == OFF_RLD);
  wire wr_cur   = bus_wr & (bus_addr == OFF_CUR);
  wire rd_ctrl  = bus_rd & (bus_addr == OFF_CTRL);
  wire ref_rise = ref_sync[1] & ~ref_sync[2];
  wire step     = en_q & (src_q | ref_rise);
  wire start    = wr_ctrl & bus_wdata[0] & ~en_q;
  wire hit      = step & (cnt_q == ONE) & ~wr_cur & ~start;
  wire unused_wbits = &{1'b0, bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) ref_sync <= '0;
    else        ref_sync <= {ref_sync[1:0], ref_clk_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; src_q <= 1'b0;
    end else if (wr_ctrl) begin
      {src_q, ie_q, en_q} <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reload_q <= '0;
    else if (wr_rld) reload_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (wr_cur | start) cnt_q <= reload_q;
    else if (step)           cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (hit)              flag_q <= 1'b1;
    else if (wr_cur | rd_ctrl) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_irq <= 1'b0;
    else        tick_irq <= hit & ie_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL:  begin
        bus_rdata[16]  = flag_q;
        bus_rdata[2:0] = {src_q, ie_q, en_q};
      end
      OFF_RLD:   bus_rdata = 32'(reload_q);
      OFF_CUR:   bus_rdata = en_q ? 32'(cnt_q) : 32'd0;
      OFF_CALIB: bus_rdata = CALIB_VAL;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tick_irq,
  input logic              en_q,
  input logic              ie_q,
  input logic              flag_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R6
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);
  // R6
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> $past(ie_q));
  // R6
  irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> flag_q);
  // R8
  cur_zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h18) && !en_q) |-> bus_rdata == 32'd0);
  // R4
  reload_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h14)) |-> bus_rdata[31:24] == 8'd0);
  // R2
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'('h10)) |-> (bus_rdata[15:3] == '0 && bus_rdata[31:17] == '0));
  // R11
  zero_reload_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && reload_q == '0 && cnt_q == '0) |=> (cnt_q == '0 && !tick_irq));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tick_irq(tick_irq), .en_q(en_q), .ie_q(ie_q),
  .flag_q(flag_q), .reload_q(reload_q), .cnt_q(cnt_q)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  localparam logic [31:0] CALIB = 32'h4000_0064;
  localparam logic [7:0] A_CTRL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, ref_clk_in = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tick_irq;

  int checks = 0, fails = 0, cyc = 0, irq_cnt = 0, ref_div = 0;
  bit ref_run = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer #(.CALIB_VAL(CALIB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_clk_in(ref_clk_in), .tick_irq(tick_irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tick_irq) irq_cnt <= irq_cnt + 1;
    if (ref_run) begin
      if (ref_div == 3) begin ref_div <= 0; ref_clk_in <= ~ref_clk_in; end
      else ref_div <= ref_div + 1;
    end
  end

  function automatic logic [31:0] ctrl_word(bit flag, logic [2:0] bits);
    return {15'd0, flag, 13'd0, bits};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (!tick_irq && n < 5000);
    t = cyc;
    if (n >= 5000) chk("irq timeout", 0, 1);
  endtask

  task automatic period(string req, int exp);
    int t0, t1;
    wait_irq(t0);
    wait_irq(t1);
    chk(req, t1 - t0, exp);
  endtask

  initial begin
    #180000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int rl, n0, t;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_RLD, d);  chk("R1 reload", d, 0);
    rd(A_CUR, d);  chk("R1 cur", d, 0);
    chk("R1 irq", tick_irq, 0);
    rd(A_CAL, d);  chk("R9 calib", d, CALIB);
    wr(A_CAL, 32'h0);
    rd(A_CAL, d);  chk("R9 calib write ignored", d, CALIB);

    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, d); chk("R2 only low bits writable", d, 0);
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, d);  chk("R4 reload 24 bits", d, 32'h00FF_FFFF);
    rd(A_CUR, d);  chk("R8 cur zero disabled", d, 0);

    wr(A_RLD, 5); wr(A_CTRL, 7);
    period("R7 period reload 5", 6);
    wr(A_CTRL, 0); wr(A_RLD, 1); wr(A_CTRL, 7);
    period("R7 period reload 1", 2);

    wr(A_CTRL, 0); wr(A_RLD, 30); wr(A_CTRL, 7);
    wait_irq(t);
    rd(A_CTRL, d); chk("R3 flag set on read", d, ctrl_word(1, 3'b111));
    rd(A_CTRL, d); chk("R3 flag cleared by read", d, ctrl_word(0, 3'b111));

    wr(A_CTRL, 0); wr(A_RLD, 10); wr(A_CTRL, 5);
    n0 = irq_cnt;
    repeat (30) @(negedge clk);
    chk("R6 no irq without ie", irq_cnt - n0, 0);
    rd(A_CTRL, d); chk("R6 flag without ie", d, ctrl_word(1, 3'b101));

    wr(A_CTRL, 0); wr(A_RLD, 100); wr(A_CTRL, 7);
    wait_irq(t);
    wr(A_CUR, 32'hDEAD_BEEF);
    rd(A_CUR, d);  chk("R5 cur write reloads", d, 100);
    rd(A_CTRL, d); chk("R5 cur write clears flag", d, ctrl_word(0, 3'b111));

    for (int i = 0; i < 6; i++) begin
      rl = int'($urandom_range(40, 1));
      wr(A_CTRL, 0); wr(A_RLD, rl); wr(A_CTRL, 7);
      rd(A_CUR, d); chk("R7 enable loads reload", d, rl);
      rd(A_CUR, d); chk("R7 first step", d, rl - 1);
      period("R7 random period", rl + 1);
    end

    wr(A_CTRL, 0); wr(A_RLD, 0); wr(A_CTRL, 7);
    rd(A_CTRL, d);
    n0 = irq_cnt;
    repeat (40) @(negedge clk);
    chk("R11 no irq at reload zero", irq_cnt - n0, 0);
    rd(A_CUR, d);  chk("R11 cur held at zero", d, 0);
    rd(A_CTRL, d); chk("R11 no flag", d, ctrl_word(0, 3'b111));

    wr(A_CTRL, 0); wr(A_RLD, 3); wr(A_CTRL, 3);
    repeat (20) @(negedge clk);
    rd(A_CUR, d);  chk("R10 holds without ref edges", d, 3);
    ref_run = 1'b1;
    period("R10 ref period", 32);
    period("R10 ref period repeat", 32);
    ref_run = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule